// File: doc/BRIEF.md
# Three-Port Controller I/O Register File

This block is the host-side register file for three 7-bit bidirectional controller ports. A host CPU reads and writes byte registers through a single-cycle strobe interface with a 4-bit offset. Each port has four registers: an output latch, a per-bit direction mask, a transmit byte and a serial-setup byte. The output latch and the direction mask drive the port pins directly. Offset 0 holds a fixed identity byte. It carries region bits, a boot-firmware-present flag and an expansion-absent flag, all set by parameters.

A read of a port's latch offset does not simply return the latch. Each bit comes either from the latch or from the live pin, depending on the direction mask. The top bit always comes from the latch, because no pin sits behind it. Every other offset reads back what it stores. When a port's drive state may have changed, the port receives a one-cycle notify pulse. A latch write always raises the pulse. A direction write raises it only if the value changes. The serial engine is not part of this block. Its setup byte only keeps the bits that the engine itself does not own.

Top module: `ctrl_port_regfile`

## Requirements
- R1: After reset, the transmit bytes of ports A, B and C (offsets 0x7, 0xA, 0xD) read 0xFF, 0xFF and 0xFB. Every other port register reads 0x00, all pin_oe bits are 0 and port_upd is 0.
- R2: Offset 0x0 reads REGION_BITS OR BOOT_FW (in bit 0) OR 0x20 when EXP_ATTACHED is 0. With the default parameters it reads 0xA1.
- R3: A write to latch offset 0x1/0x2/0x3 (ports A/B/C) sets that port's pin_out to wdata[6:0] in the cycle after the write. pin_oe of that port always equals its direction register bits [6:0], where 1 means output.
- R4: A read of a latch offset returns, for bits 6..0, the latch bit where the direction bit (offsets 0x4/0x5/0x6) is 1 and the live pin_in bit where it is 0.
- R5: Bit 7 of a latch-offset read always comes from the latch bit 7, whatever the direction register or the pins hold.
- R6: A write to a latch offset raises that port's port_upd bit (bit 0=A, 1=B, 2=C) for one cycle after the write. A write to a direction offset raises it only when the new value differs from the stored one.
- R7: Serial-setup offsets 0x9, 0xC and 0xF store only bits 7..3 of a write. Bits 2..0 read as 0.
- R8: Transmit-byte offsets store and return all 8 bits of a write.
- R9: Writes to offsets 0x0, 0x8, 0xB and 0xE have no effect. Those offsets keep reading their previous value (0x8/0xB/0xE read 0x00), and no pin or port_upd changes.
- R10: rdata changes only in the cycle after a cycle with rd_en high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pin_in | input | 21 | Live pin levels, port A in [6:0], B in [13:7], C in [20:14] |
| pin_out | output | 21 | Pin output levels, same packing |
| pin_oe | output | 21 | Pin output enables, same packing |
| port_upd | output | 3 | One-cycle drive-update notify, bit per port |

## Verification
The read merge is tried with the direction mask all clear, all set and split half and half, each against pin patterns that differ from the latch. Only the correct per-bit selection gives the expected value for all three. A latch with bit 7 set, read against all-ones and all-zero pins, separates an always-from-latch top bit from a top bit that is pin-sourced or that follows the direction mask. Direction writes are given both an unchanged and a changed value, which tells the change detector apart from a plain write strobe. Writes to read-only offsets and to neighbouring ports are followed by read-backs and pin checks, which shows the decode is not aliased.

// File: rtl/cpr_pkg.sv
package cpr_pkg;
   localparam int NPORTS = 3;

   function automatic logic [3:0] latch_off(input int p);
      return 4'(1 + p);
   endfunction

   function automatic logic [3:0] dir_off(input int p);
      return 4'(4 + p);
   endfunction

   function automatic logic [3:0] txd_off(input int p);
      return 4'(7 + 3 * p);
   endfunction

   function automatic logic [3:0] sset_off(input int p);
      return 4'(9 + 3 * p);
   endfunction

   function automatic logic [7:0] txd_init(input int p);
      return (p == 2) ? 8'hFB : 8'hFF;
   endfunction
endpackage

// File: rtl/cpr_port.sv
module cpr_port
   import cpr_pkg::*;
#(
   parameter int PORT_IDX   = 0,
   parameter int DW         = 8,
   parameter int PW         = 7,
   parameter int AW         = 4,
   parameter int SSET_RO_LSB = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] latch_q,
   output logic [DW-1:0] dir_q,
   output logic [DW-1:0] txd_q,
   output logic [DW-1:0] sset_q,
   output logic [PW-1:0] pin_out,
   output logic [PW-1:0] pin_oe,
   output logic          upd
);
   localparam logic [DW-1:0] SSET_MASK = ~DW'((1 << SSET_RO_LSB) - 1);
   localparam logic [DW-1:0] TXD_RST   = DW'(txd_init(PORT_IDX));

   logic hit_latch, hit_dir, hit_txd, hit_sset, dir_change;

   always_comb begin
      hit_latch  = wr_en && (addr == AW'(latch_off(PORT_IDX)));
      hit_dir    = wr_en && (addr == AW'(dir_off(PORT_IDX)));
      hit_txd    = wr_en && (addr == AW'(txd_off(PORT_IDX)));
      hit_sset   = wr_en && (addr == AW'(sset_off(PORT_IDX)));
      dir_change = hit_dir && (wdata != dir_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
         dir_q   <= '0;
         txd_q   <= TXD_RST;
         sset_q  <= '0;
         upd     <= 1'b0;
      end else begin
         if (hit_latch) latch_q <= wdata;
         if (dir_change) dir_q  <= wdata;
         if (hit_txd)   txd_q   <= wdata;
         if (hit_sset)  sset_q  <= wdata & SSET_MASK;
         upd <= hit_latch || dir_change;
      end
   end

   assign pin_out = latch_q[PW-1:0];
   assign pin_oe  = dir_q[PW-1:0];

   p_latch_drives_pins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hit_latch |=> (pin_out == $past(wdata[PW-1:0])));

   p_same_dir_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_dir && (wdata == dir_q) && !hit_latch) |=> !upd);

   p_latch_write_notifies_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hit_latch |=> upd);

   p_sset_low_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hit_sset |=> (sset_q == ($past(wdata) & SSET_MASK)));
endmodule

// File: rtl/cpr_rdmux.sv
module cpr_rdmux
   import cpr_pkg::*;
#(
   parameter int              DW  = 8,
   parameter int              PW  = 7,
   parameter int              AW  = 4,
   parameter logic [DW-1:0]   ID  = 8'hA1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         rd_en,
   input  logic [AW-1:0]                addr,
   input  logic [NPORTS-1:0][DW-1:0]    latch_q,
   input  logic [NPORTS-1:0][DW-1:0]    dir_q,
   input  logic [NPORTS-1:0][DW-1:0]    txd_q,
   input  logic [NPORTS-1:0][DW-1:0]    sset_q,
   input  logic [NPORTS*PW-1:0]         pin_in,
   output logic [DW-1:0]                rdata
);
   localparam logic [DW-1:0] HI_FROM_REG = ~DW'((1 << PW) - 1);

   logic [NPORTS-1:0][DW-1:0] merged;
   logic [DW-1:0]             rd_next;

   for (genvar p = 0; p < NPORTS; p++) begin : g_merge
      logic [DW-1:0] sel_reg, pins_ext;
      assign sel_reg   = dir_q[p] | HI_FROM_REG;
      assign pins_ext  = {{(DW-PW){1'b1}}, pin_in[p*PW +: PW]};
      assign merged[p] = (latch_q[p] & sel_reg) | (pins_ext & ~sel_reg);
   end

   always_comb begin
      rd_next = '0;
      if (addr == '0) rd_next = ID;
      for (int p = 0; p < NPORTS; p++) begin
         if (addr == AW'(latch_off(p))) rd_next = merged[p];
         if (addr == AW'(dir_off(p)))   rd_next = dir_q[p];
         if (addr == AW'(txd_off(p)))   rd_next = txd_q[p];
         if (addr == AW'(sset_off(p)))  rd_next = sset_q[p];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_next;
   end

   p_id_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == '0) |=> (rdata == ID));

   p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));

   p_top_bit_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == AW'(latch_off(0))) |=> (rdata[DW-1] == $past(latch_q[0][DW-1])));
endmodule

// File: rtl/ctrl_port_regfile.sv
module ctrl_port_regfile
   import cpr_pkg::*;
#(
   parameter int            DW           = 8,
   parameter int            PW           = 7,
   parameter int            AW           = 4,
   parameter logic [7:0]    REGION_BITS  = 8'h80,
   parameter bit            BOOT_FW      = 1'b1,
   parameter bit            EXP_ATTACHED = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 rd_en,
   input  logic [AW-1:0]        addr,
   input  logic [DW-1:0]        wdata,
   output logic [DW-1:0]        rdata,
   input  logic [NPORTS*PW-1:0] pin_in,
   output logic [NPORTS*PW-1:0] pin_out,
   output logic [NPORTS*PW-1:0] pin_oe,
   output logic [NPORTS-1:0]    port_upd
);
   localparam logic [DW-1:0] ID_VAL = DW'(REGION_BITS) | DW'(BOOT_FW)
                                      | (EXP_ATTACHED ? '0 : DW'(8'h20));

   if (PW >= DW) begin : g_bad_pw
      $error("pin width must be below register width");
   end
   if (AW < 4) begin : g_bad_aw
      $error("address width must cover 16 offsets");
   end
   if (DW < 6) begin : g_bad_dw
      $error("register width must hold the identity flags");
   end

   logic [NPORTS-1:0][DW-1:0] latch_q, dir_q, txd_q, sset_q;

   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      cpr_port #(
         .PORT_IDX(p), .DW(DW), .PW(PW), .AW(AW), .SSET_RO_LSB(3)
      ) u_port (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr_en),
         .addr    (addr),
         .wdata   (wdata),
         .latch_q (latch_q[p]),
         .dir_q   (dir_q[p]),
         .txd_q   (txd_q[p]),
         .sset_q  (sset_q[p]),
         .pin_out (pin_out[p*PW +: PW]),
         .pin_oe  (pin_oe[p*PW +: PW]),
         .upd     (port_upd[p])
      );
   end

   cpr_rdmux #(.DW(DW), .PW(PW), .AW(AW), .ID(ID_VAL)) u_rdmux (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .addr    (addr),
      .latch_q (latch_q),
      .dir_q   (dir_q),
      .txd_q   (txd_q),
      .sset_q  (sset_q),
      .pin_in  (pin_in),
      .rdata   (rdata)
   );

   p_ro_write_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (addr == 4'h0 || addr == 4'h8 || addr == 4'hB || addr == 4'hE))
      |=> (port_upd == '0 && $stable(pin_out) && $stable(pin_oe)));
endmodule

// File: tb/sim_ctrl_port_regfile.sv
module sim_ctrl_port_regfile;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic [20:0] pin_in = '1;
   logic [20:0] pin_out, pin_oe;
   logic [2:0]  port_upd;
   int checks = 0, fails = 0;
   logic [7:0]  rv;

   always #2 clk = ~clk;

   ctrl_port_regfile u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
      .pin_oe(pin_oe), .port_upd(port_upd)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(posedge clk);
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   function automatic logic [7:0] merge(input logic [7:0] l, input logic [7:0] dr,
                                        input logic [6:0] p);
      logic [7:0] m;
      m = dr | 8'h80;
      return (l & m) | ({1'b1, p} & ~m);
   endfunction

   task automatic t_reset;
      chk("R1 pin_oe", pin_oe, 0);
      chk("R1 port_upd", port_upd, 0);
      for (int a = 4; a < 16; a++) begin
         logic [7:0] e;
         e = (a == 7 || a == 10) ? 8'hFF : (a == 13) ? 8'hFB : 8'h00;
         rd(4'(a), rv);
         chk($sformatf("R1 offset %0h", a), rv, e);
      end
      rd(4'h0, rv); chk("R2 identity", rv, 8'hA1);
   endtask

   task automatic t_merge;
      pin_in[6:0] = 7'h2A;
      rd(4'h1, rv); chk("R4 dir clear", rv, merge(8'h00, 8'h00, 7'h2A));
      wr(4'h1, 8'h70);
      chk("R3 pin_out A", pin_out[6:0], 7'h70);
      chk("R6 latch write notify", port_upd, 3'b001);
      wr(4'h4, 8'h0F);
      chk("R3 pin_oe A", pin_oe[6:0], 7'h0F);
      chk("R6 dir change notify", port_upd, 3'b001);
      rd(4'h1, rv); chk("R4 dir split", rv, merge(8'h70, 8'h0F, 7'h2A));
      wr(4'h4, 8'h7F);
      rd(4'h1, rv); chk("R4 dir all out", rv, 8'h70);
      pin_in[13:7] = 7'h55;
      wr(4'h5, 8'h33);
      wr(4'h2, 8'h0C);
      rd(4'h2, rv); chk("R4 port B", rv, merge(8'h0C, 8'h33, 7'h55));
      chk("R3 port A kept", pin_out[6:0], 7'h70);
   endtask

   task automatic t_top_bit;
      wr(4'h6, 8'h00);
      chk("R6 same dir quiet", port_upd, 3'b000);
      wr(4'h3, 8'h80);
      chk("R6 latch C notify", port_upd, 3'b100);
      pin_in[20:14] = 7'h00;
      rd(4'h3, rv); chk("R5 bit7 latch pins low", rv, 8'h80);
      wr(4'h3, 8'h00);
      pin_in[20:14] = 7'h7F;
      rd(4'h3, rv); chk("R5 bit7 latch pins high", rv, 8'h7F);
      wr(4'h6, 8'h80);
      chk("R6 dir change C", port_upd, 3'b100);
      rd(4'h3, rv); chk("R5 bit7 with dir bit7", rv, 8'h7F);
   endtask

   task automatic t_serial;
      wr(4'h9, 8'hFF);  rd(4'h9, rv); chk("R7 sset A", rv, 8'hF8);
      wr(4'hF, 8'h0D);  rd(4'hF, rv); chk("R7 sset C", rv, 8'h08);
      wr(4'hA, 8'h3C);  rd(4'hA, rv); chk("R8 txd B", rv, 8'h3C);
      rd(4'h7, rv); chk("R8 txd A untouched", rv, 8'hFF);
      rd(4'hD, rv); chk("R8 txd C untouched", rv, 8'hFB);
   endtask

   task automatic t_readonly;
      logic [20:0] po;
      po = pin_out;
      wr(4'h0, 8'h00); chk("R9 notify off 0", port_upd, 0);
      wr(4'h8, 8'h5A); chk("R9 notify off 8", port_upd, 0);
      wr(4'hB, 8'h5A);
      wr(4'hE, 8'h5A);
      chk("R9 pins unchanged", pin_out, po);
      rd(4'h0, rv); chk("R9 identity kept", rv, 8'hA1);
      rd(4'h8, rv); chk("R9 off 8", rv, 8'h00);
      rd(4'hB, rv); chk("R9 off B", rv, 8'h00);
      rd(4'hE, rv); chk("R9 off E", rv, 8'h00);
   endtask

   task automatic t_hold;
      rd(4'hA, rv);
      wr(4'h7, 8'h11);
      @(negedge clk);
      addr = 4'h0;
      @(negedge clk);
      chk("R10 rdata hold", rdata, 8'h3C);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_merge;
      t_top_bit;
      t_serial;
      t_readonly;
      t_hold;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #200000;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule